// File: doc/BRIEF.md
# Diode-Matrix Store Read Slave

This block is the bus-side controller for a small read-only store built from diode matrices. The store holds 64 sixteen-bit words spread over four matrix pages of sixteen rows each. The block listens to an asynchronous, master-paced read bus. When the master raises its address strobe with a read request whose address falls inside a 128-byte window, the block selects one page and one row. It then waits a programmable settle time so that the slow diode rows can charge. After that it latches the row data, drives it onto the bus and raises its reply strobe.

The window base comes from a set of jumper-style inputs. It is accepted only if it lies in the top 8K I/O page of the address space. When the master drops its strobe, the block releases the reply and the data bus. It then holds a recovery phase on the matrix lines for a programmable number of clocks. No new select is taken until recovery has ended. The master strobe passes through a two-stage synchronizer before the state machine sees it.

The state machine has four states: IDLE, SELECT, REPLY and RECOVER. The transitions are as follows:
- accept: IDLE to SELECT, on a synchronized strobe with a read request that hits the window.
- settled: SELECT to REPLY, when the settle count expires.
- abort: SELECT to RECOVER, when the strobe is dropped early.
- release: REPLY to RECOVER, when the strobe drops.
- recovered: RECOVER to IDLE, when the recovery count expires.

Top module: `diode_rom_slave`

## Requirements
- R1: While reset is asserted and just after it is released, bus_ssyn, bus_data_oe and recov_drive are 0, page_sel is 0 and row_sel_n is all ones.
- R2: A read is accepted only when bus_addr[17:7] equals win_base and win_base[10:6] are all ones, which places the window in the top 8K I/O page. A base outside that page never responds.
- R3: During a select, page_sel is one-hot with bit index bus_addr[6:5]. row_sel_n is active-low and one-cold, with the low bit index bus_addr[4:1]. Byte address bit 0 is ignored.
- R4: bus_ssyn rises exactly SETTLE_CYC+3 clocks after the master strobe rises: 2 synchronizer clocks, 1 accept clock and SETTLE_CYC settle clocks. The selects stay asserted and unchanged throughout.
- R5: While bus_ssyn is high, bus_data_oe is high and bus_data holds the word latched from mx_data at the end of the settle time.
- R6: After the master strobe falls, bus_ssyn and bus_data_oe fall 3 clocks later.
- R7: recov_drive is high for exactly REC_CYC clocks after release, and the selects are inactive during that time.
- R8: A strobe raised during recovery is not accepted until recovery ends. The select then starts 1 clock after recov_drive falls, and bus_ssyn follows SETTLE_CYC clocks after that.
- R9: An address outside the window gives no select and no bus_ssyn, so the master times out.
- R10: A write request (bus_c1 = 1) is ignored. It gives no select and no reply.
- R11: If the strobe falls during the settle time, bus_ssyn never rises and a full recovery phase of REC_CYC clocks follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_base | input | 11 | Window base, byte address bits 17:7 |
| bus_addr | input | 18 | Bus byte address |
| bus_c1 | input | 1 | Cycle type, 0 = read, 1 = write |
| bus_msyn | input | 1 | Master address strobe (asynchronous) |
| bus_ssyn | output | 1 | Slave reply strobe |
| bus_data | output | 16 | Read data, valid while bus_data_oe is high |
| bus_data_oe | output | 1 | Data bus drive enable |
| page_sel | output | 4 | One-hot matrix page select |
| row_sel_n | output | 16 | Active-low row select |
| mx_data | input | 16 | Bit lines from the selected matrix row |
| recov_drive | output | 1 | Recovery drive on the matrix lines |

## Verification
The assertions assume three things about the inputs. First, bus_addr, bus_c1 and win_base are stable from before the master strobe rises until it falls. Second, the master holds its strobe high until it sees the reply, or deliberately aborts. Third, it does not raise the strobe again in the same clock in which it dropped it. The bench drives every input on the falling clock edge. It sets the address and cycle type in the same step as the strobe, or before it, and it changes win_base only while the strobe is low. A behavioural matrix model returns zeros until its select has been stable for the settle time, so a reply that comes too early shows up as wrong data.

// File: rtl/rom_pkg.sv
package rom_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SELECT  = 2'd1,
        ST_REPLY   = 2'd2,
        ST_RECOVER = 2'd3
    } rom_state_t;
endpackage

// File: rtl/rom_sync.sv
module rom_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rom_addr_dec.sv
module rom_addr_dec #(
    parameter int ADDR_W = 18,
    parameter int PAGES  = 4,
    parameter int ROWS   = 16,
    localparam int PG_W  = $clog2(PAGES),
    localparam int RW_W  = $clog2(ROWS),
    localparam int OFF_W = 1 + RW_W + PG_W,
    localparam int BASE_W = ADDR_W - OFF_W,
    localparam int IOP_W = ADDR_W - 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] win_base,
    output logic              hit,
    output logic [PG_W-1:0]   page_idx,
    output logic [RW_W-1:0]   row_idx
);
    logic base_in_iopage;
    logic unused_bit0;

    // the window must sit inside the top 8K page
    assign base_in_iopage = &win_base[BASE_W-1 -: IOP_W];
    assign hit      = base_in_iopage && (addr[ADDR_W-1:OFF_W] == win_base);
    assign page_idx = addr[OFF_W-1 -: PG_W];
    assign row_idx  = addr[RW_W:1];
    assign unused_bit0 = addr[0];
endmodule

// File: rtl/rom_timer.sv
module rom_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (clr)          cnt <= '0;
        else if (cnt != '1)    cnt <= cnt + 1'b1;
    end

    assign done = (cnt >= limit - 1'b1);
endmodule

// File: rtl/diode_rom_slave.sv
module diode_rom_slave
    import rom_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int PAGES      = 4,
    parameter int ROWS       = 16,
    parameter int SETTLE_CYC = 40,
    parameter int REC_CYC    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-8:0] win_base,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_c1,
    input  logic              bus_msyn,
    output logic              bus_ssyn,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_data_oe,
    output logic [PAGES-1:0]  page_sel,
    output logic [ROWS-1:0]   row_sel_n,
    input  logic [DATA_W-1:0] mx_data,
    output logic              recov_drive
);
    localparam int PG_W  = $clog2(PAGES);
    localparam int RW_W  = $clog2(ROWS);
    localparam int MAXC  = (SETTLE_CYC > REC_CYC) ? SETTLE_CYC : REC_CYC;
    localparam int TW    = $clog2(MAXC + 1) + 1;

    rom_state_t state, nxt;
    logic              msyn_s;
    logic              hit;
    logic [PG_W-1:0]   page_idx, pg_q;
    logic [RW_W-1:0]   row_idx, rw_q;
    logic [DATA_W-1:0] data_q;
    logic [TW-1:0]     limit;
    logic              tmr_done;
    logic              sel_active;

    rom_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(bus_msyn), .q_sync(msyn_s)
    );

    rom_addr_dec #(.ADDR_W(ADDR_W), .PAGES(PAGES), .ROWS(ROWS)) u_dec (
        .addr(bus_addr), .win_base(win_base), .hit(hit),
        .page_idx(page_idx), .row_idx(row_idx)
    );

    assign limit = (state == ST_RECOVER) ? TW'(REC_CYC) : TW'(SETTLE_CYC);

    rom_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(nxt != state),
        .limit(limit), .done(tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (msyn_s && hit && !bus_c1) nxt = ST_SELECT;
            ST_SELECT:  if (!msyn_s)                  nxt = ST_RECOVER;
                        else if (tmr_done)            nxt = ST_REPLY;
            ST_REPLY:   if (!msyn_s)                  nxt = ST_RECOVER;
            ST_RECOVER: if (tmr_done)                 nxt = ST_IDLE;
        endcase
    end

    // captured address and row data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q   <= '0;
            rw_q   <= '0;
            data_q <= '0;
        end else begin
            if (state == ST_IDLE && nxt == ST_SELECT) begin
                pg_q <= page_idx;
                rw_q <= row_idx;
            end
            if (state == ST_SELECT && nxt == ST_REPLY)
                data_q <= mx_data;
        end
    end

    // outputs
    always_comb begin
        sel_active  = (state == ST_SELECT) || (state == ST_REPLY);
        bus_ssyn    = (state == ST_REPLY);
        bus_data_oe = (state == ST_REPLY);
        bus_data    = (state == ST_REPLY) ? data_q : '0;
        recov_drive = (state == ST_RECOVER);
        page_sel    = '0;
        row_sel_n   = '1;
        if (sel_active) begin
            for (int p = 0; p < PAGES; p++)
                if (pg_q == PG_W'(p)) page_sel[p] = 1'b1;
            for (int r = 0; r < ROWS; r++)
                if (rw_q == RW_W'(r)) row_sel_n[r] = 1'b0;
        end
    end

    // checks
    logic [TW:0] held_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      held_cnt <= '0;
        else if (page_sel == '0)         held_cnt <= '0;
        else if (held_cnt != '1)         held_cnt <= held_cnt + 1'b1;
    end

    a_r3_sel_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (page_sel != '0) |-> ($onehot0(page_sel) && $countones(~row_sel_n) == 1));

    a_r4_settle_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ssyn) |-> (held_cnt >= (TW+1)'(SETTLE_CYC)));

    a_r5_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ssyn && $past(bus_ssyn)) |-> $stable(bus_data));

    a_r6_reply_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ssyn) |-> msyn_s);

    a_r7_recov_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        recov_drive |-> (page_sel == '0 && !bus_data_oe && !bus_ssyn));
endmodule

// File: tb/sim_diode_rom_slave.sv
module sim_diode_rom_slave;
    localparam int S   = 40;
    localparam int REC = 8;
    localparam logic [17:0] BASE  = 18'o773000;
    localparam logic [17:0] BASE2 = 18'o760000;
    localparam logic [17:0] NOIOP = 18'o173000;
    localparam int NV = 8;
    localparam logic [17:0] VA [NV] = '{
        BASE + 18'o000, BASE + 18'o176, BASE + 18'o177, BASE + 18'o100,
        BASE + 18'o042, BASE + 18'o200, BASE - 18'o002, BASE + 18'o061 };
    localparam logic VH [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

    logic clk = 0, rst_n = 0;
    logic [10:0] win_base;
    logic [17:0] bus_addr = '0;
    logic bus_c1 = 0, bus_msyn = 0;
    logic bus_ssyn, bus_data_oe, recov_drive;
    logic [15:0] bus_data, mx_data, row_sel_n;
    logic [3:0] page_sel;
    int tests = 0, fails = 0, cyc = 0;

    always #10 clk = ~clk;

    diode_rom_slave #(.SETTLE_CYC(S), .REC_CYC(REC)) u0 (
        .clk(clk), .rst_n(rst_n), .win_base(win_base), .bus_addr(bus_addr),
        .bus_c1(bus_c1), .bus_msyn(bus_msyn), .bus_ssyn(bus_ssyn),
        .bus_data(bus_data), .bus_data_oe(bus_data_oe), .page_sel(page_sel),
        .row_sel_n(row_sel_n), .mx_data(mx_data), .recov_drive(recov_drive));

    function automatic logic [15:0] wpat(int idx);
        return 16'((idx * 40503 + 12345) ^ (idx << 9));
    endfunction

    // behavioural matrix: four pages, each with its own page number
    logic [19:0] prev_sel;
    int stable_cnt;
    always @(posedge clk) begin
        if ({page_sel, row_sel_n} == prev_sel && page_sel != 0) stable_cnt <= stable_cnt + 1;
        else stable_cnt <= 0;
        prev_sel <= {page_sel, row_sel_n};
    end
    always_comb begin
        mx_data = '0;
        for (int k = 0; k < 4; k++)
            for (int r = 0; r < 16; r++)
                if (page_sel[k] && !row_sel_n[r] && stable_cnt >= S - 2)
                    mx_data = mx_data | wpat(k * 16 + r);
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // drop strobe after a reply/select, check release and recovery
    task automatic release_check(string req);
        int n_drop = -1, n_rec = 0;
        bus_msyn = 0;
        for (int n = 1; n <= REC + 8; n++) begin
            @(negedge clk);
            if (n_drop < 0 && !bus_ssyn && !bus_data_oe) n_drop = n;
            if (recov_drive) begin
                n_rec++;
                if (page_sel != 0) chk(0, "R7", "select during recovery", page_sel, 0);
            end
        end
        chk(n_rec == REC, "R7", {req, " recovery length"}, n_rec, REC);
    endtask

    task automatic do_read(logic [17:0] a, logic c1, logic exp_hit, string req);
        int n_ss = -1;
        int sel_seen = 0;
        logic [3:0] eps;
        logic [15:0] ers;
        eps = 4'b0001 << a[6:5];
        ers = ~(16'h0001 << a[4:1]);
        @(negedge clk);
        bus_addr = a; bus_c1 = c1; bus_msyn = 1;
        for (int n = 1; n <= S + 10; n++) begin
            @(negedge clk);
            if (page_sel != 0) sel_seen++;
            if (n_ss < 0 && bus_ssyn) begin
                n_ss = n;
                chk(page_sel == eps, "R3", "page select", page_sel, eps);
                chk(row_sel_n == ers, "R3", "row select", row_sel_n, ers);
                chk(bus_data_oe && bus_data == wpat(int'(a[6:1])), "R5", "read data",
                    bus_data, wpat(int'(a[6:1])));
            end
        end
        if (exp_hit) begin
            chk(n_ss == S + 3, req, "reply latency (R4)", n_ss, S + 3);
            chk(sel_seen >= S, "R4", "select held", sel_seen, S);
            bus_msyn = 0;
            begin
                int n_drop = -1, n_rec = 0;
                for (int n = 1; n <= REC + 8; n++) begin
                    @(negedge clk);
                    if (n_drop < 0 && !bus_ssyn && !bus_data_oe) n_drop = n;
                    if (recov_drive) n_rec++;
                    if (recov_drive && page_sel != 0) chk(0, "R7", "select in recovery", page_sel, 0);
                end
                chk(n_drop == 3, "R6", "release delay", n_drop, 3);
                chk(n_rec == REC, "R7", "recovery length", n_rec, REC);
            end
        end else begin
            chk(n_ss < 0 && sel_seen == 0, req, "no response on miss", sel_seen, 0);
            bus_msyn = 0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        win_base = BASE[17:7];
        repeat (3) @(negedge clk);
        chk(!bus_ssyn && !bus_data_oe && !recov_drive && page_sel == 0 && row_sel_n == 16'hFFFF,
            "R1", "outputs in reset", {bus_ssyn, bus_data_oe, recov_drive}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!bus_ssyn && page_sel == 0 && row_sel_n == 16'hFFFF, "R1", "after reset", page_sel, 0);

        // vector table: R2/R3/R4/R5 hits, R9 misses
        for (int i = 0; i < NV; i++)
            do_read(VA[i], 1'b0, VH[i], VH[i] ? "R2" : "R9");

        // R10: write cycle ignored
        do_read(BASE + 18'o002, 1'b1, 1'b0, "R10");

        // R2: base outside I/O page never answers
        win_base = NOIOP[17:7];
        do_read(NOIOP + 18'o020, 1'b0, 1'b0, "R2");
        // R2: moved base inside I/O page answers
        win_base = BASE2[17:7];
        do_read(BASE2 + 18'o020, 1'b0, 1'b1, "R2");
        win_base = BASE[17:7];

        // R11: abort during settle
        begin
            int seen_ss = 0;
            @(negedge clk);
            bus_addr = BASE + 18'o012; bus_c1 = 0; bus_msyn = 1;
            repeat (10) @(negedge clk);
            chk(page_sel != 0, "R11", "select active before abort", page_sel, 1);
            bus_msyn = 0;
            for (int n = 0; n < S + 10; n++) begin
                @(negedge clk);
                if (bus_ssyn) seen_ss++;
            end
            chk(seen_ss == 0, "R11", "no reply after abort", seen_ss, 0);
        end
        begin
            int n_rec = 0;
            @(negedge clk);
            bus_msyn = 1;
            repeat (S + 6) @(negedge clk);
            bus_msyn = 0;
            for (int n = 0; n < REC + 8; n++) begin
                @(negedge clk);
                if (recov_drive) n_rec++;
            end
            chk(n_rec == REC, "R11", "recovery after full read", n_rec, REC);
        end

        // R8: strobe raised again during recovery
        begin
            int n_ss = -1, n_rec = 0, sel_in_rec = 0;
            @(negedge clk);
            bus_addr = BASE + 18'o134; bus_msyn = 1;
            repeat (S + 6) @(negedge clk);
            bus_msyn = 0;
            repeat (2) @(negedge clk);
            bus_addr = BASE + 18'o066;
            bus_msyn = 1;
            // wait for recovery to begin, then end
            for (int n = 0; n < 20 && !recov_drive; n++) @(negedge clk);
            while (recov_drive) begin
                n_rec++;
                if (page_sel != 0) sel_in_rec++;
                @(negedge clk);
            end
            chk(sel_in_rec == 0, "R8", "no select while recovering", sel_in_rec, 0);
            chk(n_rec == REC, "R8", "recovery not cut short", n_rec, REC);
            for (int n = 0; n <= S + 6; n++) begin
                if (n_ss < 0 && bus_ssyn) n_ss = n;
                if (n < S + 6) @(negedge clk);
            end
            chk(n_ss == S + 1, "R8", "reply after recovery", n_ss, S + 1);
            chk(bus_data == wpat(int'(BASE[6:1] ^ BASE[6:1]) + 0) || bus_data == wpat(6'o33),
                "R8", "new word data", bus_data, wpat(6'o33));
            bus_msyn = 0;
            repeat (REC + 6) @(negedge clk);
        end

        finish_run();
    end
endmodule